// File: doc/BRIEF.md
# Grouped Priority Interrupt Resolver

This block chooses which of many pending interrupt requests should be taken next by a processor core. Each programmable request carries an 8-bit priority byte, of which only the upper `PRIO_BITS` bits are kept. A run-time group setting divides the kept byte into a preempt part, which decides nesting, and a sub part, which only orders requests that arrive together. Three fixed-rank system events (reset, non-maskable interrupt and hard fault) always outrank every programmable request.

Every cycle the resolver takes the current requests, the group setting, a global mask and a description of the handler that is running. It registers three results for the next cycle: whether any candidate exists, the winning exception number, and whether that winner is allowed to interrupt the running handler. A lower numeric priority means a more urgent request. The priority bytes arrive from the surrounding register file, and the block writes none of them back.

Top module: `gpr_resolver`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid`, `out_exc` and `out_preempt` are all zero.
- R2: The outputs have one cycle of latency. They show the result for the inputs sampled at the previous rising clock edge, and `out_valid` is 1 exactly when at least one candidate was present.
- R3: A programmable request on line i has exception number 16+i. Among programmable candidates, the one with the numerically lowest kept priority byte wins.
- R4: Only bits [7:8-PRIO_BITS] of each priority byte take part. With the default `PRIO_BITS`=3, bits [4:0] have no effect on selection or on preemption.
- R5: When two programmable candidates have equal kept bytes, the lower line index wins.
- R6: For a group value g from 0 to 6, the preempt part of a byte is bits [7:g+1]. A group value of 7 gives an empty preempt part.
- R7: A programmable winner may preempt a running programmable handler only when its preempt part is strictly lower than the running handler's preempt part. Sub bits never grant preemption.
- R8: Among candidates that share the same preempt part, the lower sub bits win the selection.
- R9: With group 7, a programmable winner never preempts a running programmable handler.
- R10: `sys_pend` bit 2 is reset (exception 1), bit 1 is NMI (exception 2) and bit 0 is hard fault (exception 3). They rank reset over NMI over hard fault, and all three rank over every programmable request.
- R11: `run_sys` describes the running handler: 0 means programmable (or none), 1 hard fault, 2 NMI, 3 reset. A fixed winner preempts a running programmable handler, and preempts a running fixed handler only when the winner ranks strictly higher.
- R12: While `glb_mask` is 1, programmable requests are not candidates. Fixed requests are still resolved.
- R13: When `run_active` is 0, `out_preempt` equals `out_valid`. Whenever `out_valid` is 0, `out_exc` and `out_preempt` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | NUM_IRQ | Pending-and-enabled programmable requests, one bit per line |
| irq_prio | input | NUM_IRQ*8 | Priority bytes; byte i sits at bits [8i+7:8i] |
| sys_pend | input | 3 | Fixed requests: bit 2 reset, bit 1 NMI, bit 0 hard fault |
| prio_group | input | 3 | Split point between preempt and sub bits |
| glb_mask | input | 1 | Removes all programmable requests when 1 |
| run_active | input | 1 | A handler is currently running |
| run_sys | input | 2 | Running handler kind: 0 programmable, 1 hard fault, 2 NMI, 3 reset |
| run_prio | input | 8 | Priority byte of the running programmable handler |
| out_valid | output | 1 | A candidate was found |
| out_exc | output | 9 | Winning exception number |
| out_preempt | output | 1 | The winner may interrupt the running handler |

## Verification
Selection and the preemption decision are resolved in the same cycle from different slices of the same byte. The bench therefore builds cases where these two disagree. In one case the sub bits pick the winner, but the winner's preempt part equals the running level, so preemption must be refused. In another, the same pair of bytes is replayed under several group values so that only the split point moves. A second collision arises when fixed and programmable requests, or the global mask, are present together. In those cases the fixed event must win and its preemption must be judged against the running fixed rank, not the programmable bytes.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int EXC_W        = 9;
    localparam int EXC_RESET    = 1;
    localparam int EXC_NMI      = 2;
    localparam int EXC_HARD     = 3;
    localparam int EXC_IRQ_BASE = 16;

    // Registered result of one resolution.
    typedef struct packed {
        logic             valid;
        logic [EXC_W-1:0] exc;
        logic             preempt;
    } gpr_out_t;

    // Mask selecting the preempt part of a priority byte for group g.
    function automatic logic [7:0] preempt_mask(input logic [2:0] g);
        logic [3:0] sh;
        sh = {1'b0, g} + 4'd1;
        if (g == 3'd7) begin
            return 8'h00;
        end
        return 8'hFF << sh;
    endfunction

endpackage

// File: rtl/gpr_prio_norm.sv
module gpr_prio_norm #(
    parameter int NUM_IRQ   = 16,
    parameter int PRIO_BITS = 3
) (
    input  logic [NUM_IRQ*8-1:0] raw_prio,
    output logic [NUM_IRQ*8-1:0] eff_prio
);
    localparam logic [7:0] KEEP_MASK = 8'hFF << (8 - PRIO_BITS);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        assign eff_prio[i*8 +: 8] = raw_prio[i*8 +: 8] & KEEP_MASK;
    end
endmodule

// File: rtl/gpr_pick.sv
module gpr_pick #(
    parameter int NUM_IRQ = 16,
    localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0]   req,
    input  logic [NUM_IRQ*8-1:0] eff_prio,
    output logic                 found,
    output logic [IDX_W-1:0]     win_idx,
    output logic [7:0]           win_prio
);
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = 8'hFF;
        for (int i = 0; i < NUM_IRQ; i++) begin
            // strict compare keeps the lowest index on equal bytes
            if (req[i] && (!found || (eff_prio[i*8 +: 8] < win_prio))) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = eff_prio[i*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/gpr_fixed.sv
module gpr_fixed
    import gpr_pkg::*;
(
    input  logic [2:0]       sys_pend,
    output logic             found,
    output logic [1:0]       rank,
    output logic [EXC_W-1:0] exc
);
    always_comb begin
        found = 1'b1;
        if (sys_pend[2]) begin
            rank = 2'd3;
            exc  = EXC_W'(EXC_RESET);
        end else if (sys_pend[1]) begin
            rank = 2'd2;
            exc  = EXC_W'(EXC_NMI);
        end else if (sys_pend[0]) begin
            rank = 2'd1;
            exc  = EXC_W'(EXC_HARD);
        end else begin
            found = 1'b0;
            rank  = 2'd0;
            exc   = '0;
        end
    end
endmodule

// File: rtl/gpr_preempt.sv
module gpr_preempt
    import gpr_pkg::*;
(
    input  logic       cand_valid,
    input  logic       cand_fixed,
    input  logic [1:0] cand_rank,
    input  logic [7:0] cand_prio,
    input  logic       run_active,
    input  logic [1:0] run_sys,
    input  logic [7:0] run_prio,
    input  logic [2:0] group,
    output logic       allow
);
    logic [7:0] pmask;
    logic [7:0] cand_pre;
    logic [7:0] run_pre;

    always_comb begin
        pmask    = preempt_mask(group);
        cand_pre = cand_prio & pmask;
        run_pre  = run_prio & pmask;
        if (!cand_valid) begin
            allow = 1'b0;
        end else if (!run_active) begin
            allow = 1'b1;
        end else if (run_sys != 2'd0) begin
            allow = cand_fixed && (cand_rank > run_sys);
        end else if (cand_fixed) begin
            allow = 1'b1;
        end else begin
            allow = cand_pre < run_pre;
        end
    end
endmodule

// File: rtl/gpr_resolver.sv
module gpr_resolver
    import gpr_pkg::*;
#(
    parameter int NUM_IRQ   = 16,
    parameter int PRIO_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQ-1:0]   irq_pend,
    input  logic [NUM_IRQ*8-1:0] irq_prio,
    input  logic [2:0]           sys_pend,
    input  logic [2:0]           prio_group,
    input  logic                 glb_mask,
    input  logic                 run_active,
    input  logic [1:0]           run_sys,
    input  logic [7:0]           run_prio,
    output logic                 out_valid,
    output logic [8:0]           out_exc,
    output logic                 out_preempt
);
    localparam int IDX_W         = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam logic [7:0] KEEP  = 8'hFF << (8 - PRIO_BITS);

    logic [NUM_IRQ*8-1:0] eff_prio;
    logic [NUM_IRQ-1:0]   prog_req;
    logic                 prog_found;
    logic [IDX_W-1:0]     prog_idx;
    logic [7:0]           prog_prio;
    logic                 fix_found;
    logic [1:0]           fix_rank;
    logic [EXC_W-1:0]     fix_exc;
    logic                 allow;
    logic [7:0]           run_eff;

    gpr_out_t res_d, res_q;

    assign prog_req = irq_pend & {NUM_IRQ{~glb_mask}};
    assign run_eff  = run_prio & KEEP;

    gpr_prio_norm #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_norm (
        .raw_prio (irq_prio),
        .eff_prio (eff_prio)
    );

    gpr_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
        .req      (prog_req),
        .eff_prio (eff_prio),
        .found    (prog_found),
        .win_idx  (prog_idx),
        .win_prio (prog_prio)
    );

    gpr_fixed u_fixed (
        .sys_pend (sys_pend),
        .found    (fix_found),
        .rank     (fix_rank),
        .exc      (fix_exc)
    );

    gpr_preempt u_pre (
        .cand_valid (fix_found | prog_found),
        .cand_fixed (fix_found),
        .cand_rank  (fix_rank),
        .cand_prio  (prog_prio),
        .run_active (run_active),
        .run_sys    (run_sys),
        .run_prio   (run_eff),
        .group      (prio_group),
        .allow      (allow)
    );

    always_comb begin
        res_d = '0;
        if (fix_found) begin
            res_d.valid   = 1'b1;
            res_d.exc     = fix_exc;
            res_d.preempt = allow;
        end else if (prog_found) begin
            res_d.valid   = 1'b1;
            res_d.exc     = EXC_W'(EXC_IRQ_BASE) + EXC_W'(prog_idx);
            res_d.preempt = allow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign out_exc     = res_q.exc;
    assign out_preempt = res_q.preempt;
endmodule

// File: rtl/gpr_resolver_chk.sv
module gpr_resolver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] sys_pend,
    input logic [2:0] prio_group,
    input logic       glb_mask,
    input logic       run_active,
    input logic [1:0] run_sys,
    input logic       out_valid,
    input logic [8:0] out_exc,
    input logic       out_preempt
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    // R13
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_exc == 9'd0 && !out_preempt));

    // R10
    reset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(sys_pend[2])) |-> (out_valid && out_exc == 9'd1));

    // R12
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(glb_mask && sys_pend == 3'b000)) |-> !out_valid);

    // R9
    group_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(prio_group == 3'd7 && run_active && run_sys == 2'd0
                          && sys_pend == 3'b000)) |-> !out_preempt);

    // R13
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!run_active)) |-> (out_preempt == out_valid));

    // R11
    top_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(run_active && run_sys == 2'd3)) |-> !out_preempt);
endmodule

bind gpr_resolver gpr_resolver_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_pend    (sys_pend),
    .prio_group  (prio_group),
    .glb_mask    (glb_mask),
    .run_active  (run_active),
    .run_sys     (run_sys),
    .out_valid   (out_valid),
    .out_exc     (out_exc),
    .out_preempt (out_preempt)
);

// File: tb/gpr_resolver_bench.sv
`timescale 1ns/1ps
module gpr_resolver_bench;
    localparam int NUM_IRQ   = 16;
    localparam int PRIO_BITS = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NUM_IRQ-1:0]   irq_pend;
    logic [NUM_IRQ*8-1:0] irq_prio;
    logic [2:0]           sys_pend;
    logic [2:0]           prio_group;
    logic                 glb_mask;
    logic                 run_active;
    logic [1:0]           run_sys;
    logic [7:0]           run_prio;
    logic                 out_valid;
    logic [8:0]           out_exc;
    logic                 out_preempt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpr_resolver #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_gpr_resolver (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_prio(irq_prio),
        .sys_pend(sys_pend), .prio_group(prio_group), .glb_mask(glb_mask),
        .run_active(run_active), .run_sys(run_sys), .run_prio(run_prio),
        .out_valid(out_valid), .out_exc(out_exc), .out_preempt(out_preempt)
    );

    task automatic clear_in();
        irq_pend   = '0;
        irq_prio   = '0;
        sys_pend   = '0;
        prio_group = '0;
        glb_mask   = 1'b0;
        run_active = 1'b0;
        run_sys    = '0;
        run_prio   = '0;
    endtask

    task automatic req(input int idx, input logic [7:0] p);
        irq_pend[idx]        = 1'b1;
        irq_prio[idx*8 +: 8] = p;
    endtask

    // Inputs are set just after a falling edge; result is read one falling edge later.
    task automatic expect_out(input string tag, input logic v, input logic [8:0] e, input logic p);
        @(negedge clk);
        checks++;
        if (out_valid !== v || out_exc !== e || out_preempt !== p) begin
            errors++;
            $display("FAIL %s: got valid=%0b exc=%0d pre=%0b, expected valid=%0b exc=%0d pre=%0b",
                     tag, out_valid, out_exc, out_preempt, v, e, p);
        end
    endtask

    task automatic t_reset();
        clear_in();
        req(4, 8'h00);
        sys_pend = 3'b100;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_exc !== 9'd0 || out_preempt !== 1'b0) begin
            errors++;
            $display("FAIL R1: got valid=%0b exc=%0d pre=%0b, expected 0/0/0",
                     out_valid, out_exc, out_preempt);
        end
        rst_n = 1'b1;
        clear_in();
        expect_out("R1", 1'b0, 9'd0, 1'b0);
    endtask

    task automatic t_basic();
        clear_in(); req(5, 8'h40);
        expect_out("R2", 1'b1, 9'd21, 1'b1);
        clear_in(); req(2, 8'h60); req(7, 8'h40);
        expect_out("R3", 1'b1, 9'd23, 1'b1);
        clear_in(); req(15, 8'hE0);
        expect_out("R3", 1'b1, 9'd31, 1'b1);
        clear_in();
        expect_out("R2", 1'b0, 9'd0, 1'b0);
    endtask

    task automatic t_lowbits();
        clear_in(); req(1, 8'h5F); req(3, 8'h40);
        expect_out("R4", 1'b1, 9'd17, 1'b1);
        clear_in(); req(0, 8'h1F); run_active = 1'b1; run_prio = 8'h00;
        expect_out("R4", 1'b1, 9'd16, 1'b0);
    endtask

    task automatic t_tie();
        clear_in(); req(9, 8'h80); req(4, 8'h80);
        expect_out("R5", 1'b1, 9'd20, 1'b1);
    endtask

    task automatic t_groups();
        clear_in(); req(0, 8'h20); run_active = 1'b1; run_prio = 8'h40;
        prio_group = 3'd0;
        expect_out("R6", 1'b1, 9'd16, 1'b1);
        prio_group = 3'd4;
        expect_out("R6", 1'b1, 9'd16, 1'b1);
        prio_group = 3'd5;
        expect_out("R6", 1'b1, 9'd16, 1'b1);
        prio_group = 3'd6;
        expect_out("R6", 1'b1, 9'd16, 1'b0);
        clear_in(); req(0, 8'h60); run_active = 1'b1; run_prio = 8'h40; prio_group = 3'd5;
        expect_out("R7", 1'b1, 9'd16, 1'b0);
    endtask

    task automatic t_sub();
        clear_in(); req(3, 8'h60); req(10, 8'h40); prio_group = 3'd5;
        run_active = 1'b1; run_prio = 8'h60;
        expect_out("R8", 1'b1, 9'd26, 1'b0);
        run_prio = 8'h80;
        expect_out("R7", 1'b1, 9'd26, 1'b1);
    endtask

    task automatic t_group7();
        clear_in(); req(6, 8'h00); prio_group = 3'd7;
        run_active = 1'b1; run_prio = 8'hE0;
        expect_out("R9", 1'b1, 9'd22, 1'b0);
        sys_pend = 3'b001;
        expect_out("R9", 1'b1, 9'd3, 1'b1);
    endtask

    task automatic t_fixed();
        clear_in(); req(0, 8'h00); sys_pend = 3'b011;
        expect_out("R10", 1'b1, 9'd2, 1'b1);
        sys_pend = 3'b111;
        expect_out("R10", 1'b1, 9'd1, 1'b1);
        clear_in(); sys_pend = 3'b001; run_active = 1'b1; run_sys = 2'd2;
        expect_out("R11", 1'b1, 9'd3, 1'b0);
        sys_pend = 3'b100;
        expect_out("R11", 1'b1, 9'd1, 1'b1);
        clear_in(); sys_pend = 3'b010; run_active = 1'b1; run_sys = 2'd2;
        expect_out("R11", 1'b1, 9'd2, 1'b0);
        clear_in(); req(2, 8'h00); run_active = 1'b1; run_sys = 2'd1;
        expect_out("R11", 1'b1, 9'd18, 1'b0);
    endtask

    task automatic t_mask();
        clear_in(); req(8, 8'h00); glb_mask = 1'b1;
        expect_out("R12", 1'b0, 9'd0, 1'b0);
        sys_pend = 3'b001;
        expect_out("R12", 1'b1, 9'd3, 1'b1);
        glb_mask = 1'b0; sys_pend = 3'b000;
        expect_out("R13", 1'b1, 9'd24, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_in();
        t_reset();
        t_basic();
        t_lowbits();
        t_tie();
        t_groups();
        t_sub();
        t_group7();
        t_fixed();
        t_mask();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule